// File: doc/BRIEF.md
# Supervisor Trap and Control Register Page

This block is the privileged slice of a byte-wide control register page. It keeps a single privilege bit (supervisor or user) and watches every write into the page. While the core runs in user mode, a write to any offset of a 64-entry trap window (offsets 0x40 to 0x7F) is not stored. Instead it becomes a one-cycle trap request whose trap number is the offset's distance from the window base, and the block enters supervisor mode on that same clock edge. The processor's context save and restore happens elsewhere; this block only raises the request and switches privilege.

In supervisor mode the window offsets are ordinary registers. Writing the exit offset drops back to user mode. A feature register drives two enables: extended opcodes and ROM write protection. An upgrade marker becomes all-ones on any write and stays that way until reset. A key value written to the reconfiguration offset produces a single-cycle request pulse. The page also reads back the board switch bank and two fixed multi-byte identifiers. Reads are combinational from the offset.

Top module: `sup_trap_page`

## Requirements
- R1: After a synchronous active-low reset the block is in supervisor mode (super_mode=1). ext_ops_en, rom_wp_en, trap_req and reconfig_req are 0, and offset 0x7E reads 0x00.
- R2: A user-mode write to an offset in 0x40..0x7F raises trap_req for exactly one cycle after the write edge, with trap_num = offset - 0x40. super_mode becomes 1 on the same edge.
- R3: A trapped write stores nothing: the feature bits and the upgrade marker keep their values.
- R4: A supervisor-mode write to an offset in the window never traps. A supervisor write to offset 0x7F sets super_mode to 0 on the next edge.
- R5: Reading offset 0x7F returns 0x48 ('H') in supervisor mode and 0x55 ('U') in user mode.
- R6: Any non-trapped write to offset 0x7E makes that offset read 0xFF. It stays 0xFF through later writes until reset.
- R7: A non-trapped write to offset 0x7D loads bit 1 into ext_ops_en and bit 2 into rom_wp_en. Reading 0x7D returns those two bits in positions 1 and 2, with 0 elsewhere.
- R8: A non-trapped write of 0x42 to offset 0xCF, in either mode, pulses reconfig_req for one cycle after the edge. Any other value written there gives no pulse.
- R9: Offset 0xF0 reads board_sw[7:0] and offset 0xF1 reads board_sw[15:8].
- R10: Offsets 0x32..0x35 read identifier A, and offsets 0x2C..0x2F read identifier B. Each is little-endian: the byte at base+k is bits 8k+7..8k.
- R11: All other offsets read 0x00. Writes outside the window and outside 0x7D, 0x7E and 0xCF change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the page |
| reg_addr | input | 8 | Page offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| board_sw | input | 8*SW_BYTES (16) | Board switch bank |
| super_mode | output | 1 | 1 = supervisor, 0 = user |
| trap_req | output | 1 | One-cycle trap request |
| trap_num | output | TRAP_W (6) | Trap number, valid with trap_req |
| ext_ops_en | output | 1 | Extended opcode enable |
| rom_wp_en | output | 1 | ROM write protection enable |
| reconfig_req | output | 1 | One-cycle reconfiguration request |

## Verification
The bench builds the block with its default widths: an 8-bit offset, a 64-entry window, two switch bytes and four-byte identifiers. Both identifiers are overridden with distinct byte patterns, so a byte-order or offset slip shows up. At these sizes it can write every one of the 256 offsets in user mode and check whether each one traps. It reads all 256 offsets in both privilege modes, writes every data value to the reconfiguration offset, and walks a single set bit across the switch bank.

// File: rtl/sup_page_pkg.sv
// Package: offsets, key values and shared types of the supervisor page.
// Assumes a byte-wide page; offsets are fixed because software decodes them.
package sup_page_pkg;
    typedef logic [7:0] page_byte_t;

    localparam page_byte_t OFS_EXIT   = 8'h7F;
    localparam page_byte_t OFS_UPG    = 8'h7E;
    localparam page_byte_t OFS_FEAT   = 8'h7D;
    localparam page_byte_t OFS_RECFG  = 8'hCF;
    localparam page_byte_t RECFG_KEY  = 8'h42;
    localparam page_byte_t OFS_SW_LO  = 8'hF0;
    localparam page_byte_t OFS_IDA    = 8'h32;
    localparam page_byte_t OFS_IDB    = 8'h2C;
    localparam page_byte_t CHAR_SUP   = 8'h48;
    localparam page_byte_t CHAR_USR   = 8'h55;
    localparam int         FEAT_EXT_BIT = 1;
    localparam int         FEAT_ROM_BIT = 2;

    typedef struct packed {
        logic rom_wp;
        logic ext_ops;
    } feat_t;
endpackage

// File: rtl/sup_priv_ctl.sv
// Privilege tracker and trap generator.
// A user-mode write inside the trap window is swallowed and turned into a
// registered one-cycle trap pulse; supervisor mode is entered on that edge.
// Assumes the window lies inside the 8-bit page.
module sup_priv_ctl
    import sup_page_pkg::*;
#(
    parameter page_byte_t TRAP_LO   = 8'h40,
    parameter int         TRAP_SPAN = 64,
    localparam int        TRAP_W    = $clog2(TRAP_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  page_byte_t        addr,
    output logic              super_mode,
    output logic              trap_req,
    output logic [TRAP_W-1:0] trap_num,
    output logic              wr_ok
);
    localparam int TRAP_HI = int'(TRAP_LO) + TRAP_SPAN;

    logic in_win;
    logic trap_hit;

    // Decode window membership and whether this write is trapped.
    always_comb begin
        in_win   = (int'(addr) >= int'(TRAP_LO)) && (int'(addr) < TRAP_HI);
        trap_hit = we && !super_mode && in_win;
        wr_ok    = we && !trap_hit;
    end

    // Privilege bit, trap pulse and trap number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            super_mode <= 1'b1;
            trap_req   <= 1'b0;
            trap_num   <= '0;
        end else begin
            trap_req <= trap_hit;
            if (trap_hit) begin
                super_mode <= 1'b1;
                trap_num   <= TRAP_W'(addr - TRAP_LO);
            end else if (super_mode && we && addr == OFS_EXIT) begin
                super_mode <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sup_cfg_regs.sv
// Writable control state: feature enables, sticky upgrade marker and the
// keyed reconfiguration pulse. Only accepts writes already cleared by the
// privilege tracker (wr_ok).
module sup_cfg_regs
    import sup_page_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  page_byte_t addr,
    input  page_byte_t wdata,
    output feat_t      feat,
    output logic       upgraded,
    output logic       reconfig_req
);
    // Register the control state and generate the one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat         <= '0;
            upgraded     <= 1'b0;
            reconfig_req <= 1'b0;
        end else begin
            reconfig_req <= wr_ok && (addr == OFS_RECFG) && (wdata == RECFG_KEY);
            if (wr_ok && addr == OFS_FEAT) begin
                feat.ext_ops <= wdata[FEAT_EXT_BIT];
                feat.rom_wp  <= wdata[FEAT_ROM_BIT];
            end
            if (wr_ok && addr == OFS_UPG)
                upgraded <= 1'b1;
        end
    end
endmodule

// File: rtl/sup_read_mux.sv
// Combinational readback of the page. Identifier and switch bytes are
// generated per byte; the identifier ranges must not overlap each other,
// the switch bytes or the fixed control offsets.
module sup_read_mux
    import sup_page_pkg::*;
#(
    parameter int ID_BYTES = 4,
    parameter int SW_BYTES = 2,
    parameter logic [8*ID_BYTES-1:0] ID_A = '0,
    parameter logic [8*ID_BYTES-1:0] ID_B = '0
) (
    input  page_byte_t              addr,
    input  logic                    super_mode,
    input  feat_t                   feat,
    input  logic                    upgraded,
    input  logic [8*SW_BYTES-1:0]   board_sw,
    output page_byte_t              rdata
);
    page_byte_t            ida_byte [ID_BYTES];
    page_byte_t            idb_byte [ID_BYTES];
    page_byte_t            sw_byte  [SW_BYTES];
    logic [ID_BYTES-1:0]   ida_hit;
    logic [ID_BYTES-1:0]   idb_hit;
    logic [SW_BYTES-1:0]   sw_hit;

    for (genvar k = 0; k < ID_BYTES; k++) begin : g_id
        assign ida_hit[k]  = (addr == 8'(int'(OFS_IDA) + k));
        assign idb_hit[k]  = (addr == 8'(int'(OFS_IDB) + k));
        assign ida_byte[k] = ID_A[8*k +: 8];
        assign idb_byte[k] = ID_B[8*k +: 8];
    end

    for (genvar k = 0; k < SW_BYTES; k++) begin : g_sw
        assign sw_hit[k]  = (addr == 8'(int'(OFS_SW_LO) + k));
        assign sw_byte[k] = board_sw[8*k +: 8];
    end

    // Select the byte for the current offset; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < ID_BYTES; k++) begin
            if (ida_hit[k]) rdata = ida_byte[k];
            if (idb_hit[k]) rdata = idb_byte[k];
        end
        for (int k = 0; k < SW_BYTES; k++) begin
            if (sw_hit[k]) rdata = sw_byte[k];
        end
        case (addr)
            OFS_EXIT: rdata = super_mode ? CHAR_SUP : CHAR_USR;
            OFS_UPG:  rdata = upgraded ? 8'hFF : 8'h00;
            OFS_FEAT: begin
                rdata = '0;
                rdata[FEAT_EXT_BIT] = feat.ext_ops;
                rdata[FEAT_ROM_BIT] = feat.rom_wp;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sup_trap_page.sv
// Top of the supervisor trap and control page. Wires the privilege
// tracker, the control registers and the readback mux. Assumes a single
// write strobe per cycle and a combinational read path.
module sup_trap_page
    import sup_page_pkg::*;
#(
    parameter page_byte_t TRAP_LO   = 8'h40,
    parameter int         TRAP_SPAN = 64,
    parameter int         SW_BYTES  = 2,
    parameter int         ID_BYTES  = 4,
    parameter logic [8*ID_BYTES-1:0] ID_A = 32'h706F_6F6C,
    parameter logic [8*ID_BYTES-1:0] ID_B = 32'h2131_3076,
    localparam int        TRAP_W    = $clog2(TRAP_SPAN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [7:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic [8*SW_BYTES-1:0] board_sw,
    output logic                  super_mode,
    output logic                  trap_req,
    output logic [TRAP_W-1:0]     trap_num,
    output logic                  ext_ops_en,
    output logic                  rom_wp_en,
    output logic                  reconfig_req
);
    logic  wr_ok;
    feat_t feat;
    logic  upgraded;

    sup_priv_ctl #(.TRAP_LO(TRAP_LO), .TRAP_SPAN(TRAP_SPAN)) u_priv (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .super_mode (super_mode),
        .trap_req   (trap_req),
        .trap_num   (trap_num),
        .wr_ok      (wr_ok)
    );

    sup_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ok        (wr_ok),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .feat         (feat),
        .upgraded     (upgraded),
        .reconfig_req (reconfig_req)
    );

    sup_read_mux #(
        .ID_BYTES (ID_BYTES),
        .SW_BYTES (SW_BYTES),
        .ID_A     (ID_A),
        .ID_B     (ID_B)
    ) u_rd (
        .addr       (reg_addr),
        .super_mode (super_mode),
        .feat       (feat),
        .upgraded   (upgraded),
        .board_sw   (board_sw),
        .rdata      (reg_rdata)
    );

    // Drive the feature enables from the stored feature bits.
    always_comb begin
        ext_ops_en = feat.ext_ops;
        rom_wp_en  = feat.rom_wp;
    end
endmodule

// File: rtl/sup_trap_page_chk.sv
// Checker for sup_trap_page, attached by bind. Observes ports only.
module sup_trap_page_chk #(
    parameter logic [7:0] TRAP_LO   = 8'h40,
    parameter int         TRAP_SPAN = 64,
    localparam int        TRAP_W    = $clog2(TRAP_SPAN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [7:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              super_mode,
    input logic              trap_req,
    input logic [TRAP_W-1:0] trap_num,
    input logic              ext_ops_en,
    input logic              rom_wp_en,
    input logic              reconfig_req
);
    logic win;
    assign win = (int'(reg_addr) >= int'(TRAP_LO)) &&
                 (int'(reg_addr) <  int'(TRAP_LO) + TRAP_SPAN);

    // R2: user write in window traps with the right number
    a_r2_user_window_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !super_mode && win) |=>
        (trap_req && super_mode && trap_num == TRAP_W'($past(reg_addr) - TRAP_LO)));

    // R2: trap request lasts one cycle
    a_r2_trap_single: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    // R2: a trap only follows a user write in the window
    a_r2_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(reg_we && !super_mode && win));

    // R4: supervisor write to exit offset returns to user mode
    a_r4_exit_to_user: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && super_mode && reg_addr == 8'h7F) |=> !super_mode);

    // R3: feature enables move only on a supervisor write of the feature offset
    a_r3_feat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && super_mode && reg_addr == 8'h7D) |=> $stable({ext_ops_en, rom_wp_en}));

    // R8: reconfiguration pulse only after the key write
    a_r8_recfg_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig_req |-> $past(reg_we && reg_addr == 8'hCF && reg_wdata == 8'h42));

    // R5: mode character readback
    a_r5_mode_char: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h7F) |-> (reg_rdata == (super_mode ? 8'h48 : 8'h55)));
endmodule

bind sup_trap_page sup_trap_page_chk #(.TRAP_LO(TRAP_LO), .TRAP_SPAN(TRAP_SPAN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .super_mode   (super_mode),
    .trap_req     (trap_req),
    .trap_num     (trap_num),
    .ext_ops_en   (ext_ops_en),
    .rom_wp_en    (rom_wp_en),
    .reconfig_req (reconfig_req)
);

// File: tb/sim_sup_trap_page.sv
module sim_sup_trap_page;
    localparam logic [31:0] TB_IDA = 32'h5A3C_961E;
    localparam logic [31:0] TB_IDB = 32'hC3E1_0F87;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [15:0] board_sw = 16'h0000;
    logic        super_mode, trap_req, ext_ops_en, rom_wp_en, reconfig_req;
    logic [5:0]  trap_num;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model of the architectural state.
    bit m_sup, m_upg, m_ext, m_rom;

    always #5 clk = ~clk;

    sup_trap_page #(.ID_A(TB_IDA), .ID_B(TB_IDB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .board_sw(board_sw),
        .super_mode(super_mode), .trap_req(trap_req), .trap_num(trap_num),
        .ext_ops_en(ext_ops_en), .rom_wp_en(rom_wp_en), .reconfig_req(reconfig_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h7F) return m_sup ? 8'h48 : 8'h55;
        if (a == 8'h7E) return m_upg ? 8'hFF : 8'h00;
        if (a == 8'h7D) return {5'b0, m_rom, m_ext, 1'b0};
        if (a == 8'hF0) return board_sw[7:0];
        if (a == 8'hF1) return board_sw[15:8];
        if (a >= 8'h32 && a <= 8'h35) return 8'(TB_IDA >> (8 * (a - 8'h32)));
        if (a >= 8'h2C && a <= 8'h2F) return 8'(TB_IDB >> (8 * (a - 8'h2C)));
        return 8'h00;
    endfunction

    // One write cycle; returns at the negedge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp_rd(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_sup = 1; m_upg = 0; m_ext = 0; m_rom = 0;
        @(negedge clk);
    endtask

    task automatic chk_reset_state();
        chk("R1 super after reset", super_mode, 1);
        chk("R1 ext after reset", ext_ops_en, 0);
        chk("R1 rom after reset", rom_wp_en, 0);
        chk("R1 trap after reset", trap_req, 0);
        chk("R1 recfg after reset", reconfig_req, 0);
        rd(8'h7E, "R1 upgrade marker after reset");
        rd(8'h7D, "R1 feature readback after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk_reset_state();

        // R5 R10 R11: read sweep of every offset in supervisor mode.
        board_sw = 16'hA55A;
        for (int a = 0; a < 256; a++) rd(8'(a), "R10/R11 supervisor read sweep");

        // R9: walk a single bit across the switch bank.
        for (int i = 0; i < 16; i++) begin
            board_sw = 16'h0001 << i;
            rd(8'hF0, "R9 switch low byte");
            rd(8'hF1, "R9 switch high byte");
        end

        // R7: feature register loads.
        wr(8'h7D, 8'hFF); m_ext = 1; m_rom = 1;
        chk("R7 ext set", ext_ops_en, 1);
        chk("R7 rom set", rom_wp_en, 1);
        rd(8'h7D, "R7 feature readback both");
        wr(8'h7D, 8'h02); m_rom = 0;
        chk("R7 ext only", ext_ops_en, 1);
        chk("R7 rom cleared", rom_wp_en, 0);
        rd(8'h7D, "R7 feature readback ext");

        // R6: sticky upgrade marker.
        wr(8'h7E, 8'h00); m_upg = 1;
        rd(8'h7E, "R6 marker set");
        wr(8'h7E, 8'h12);
        rd(8'h7E, "R6 marker stays");

        // R8: every data value on the reconfiguration offset.
        for (int d = 0; d < 256; d++) begin
            wr(8'hCF, 8'(d));
            chk("R8 recfg pulse vs key", reconfig_req, (d == 8'h42) ? 1 : 0);
            @(negedge clk);
            chk("R8 recfg pulse width", reconfig_req, 0);
        end

        // R4: supervisor writes into the window (not the exit/control offsets) never trap.
        for (int a = 8'h40; a < 8'h7D; a++) begin
            wr(8'(a), 8'h00);
            chk("R4 no trap in supervisor", trap_req, 0);
            chk("R4 stays supervisor", super_mode, 1);
        end
        chk("R11 ext kept", ext_ops_en, 1);

        // R4 R5: leave supervisor mode.
        wr(8'h7F, 8'h00); m_sup = 0;
        chk("R4 exit to user", super_mode, 0);
        rd(8'h7F, "R5 user mode character");

        // R10 R11 R5: read sweep in user mode.
        board_sw = 16'h3CC3;
        for (int a = 0; a < 256; a++) rd(8'(a), "R5/R11 user read sweep");

        // R2 R3 R11: user write to every offset.
        for (int a = 0; a < 256; a++) begin
            bit inw;
            inw = (a >= 8'h40) && (a < 8'h80);
            wr(8'(a), 8'h00);
            chk("R2 trap request", trap_req, inw ? 1 : 0);
            if (inw) chk("R2 trap number", trap_num, 32'(a - 8'h40));
            chk("R2 supervisor on trap", super_mode, inw ? 1 : 0);
            chk("R11 no recfg on zero", reconfig_req, 0);
            chk("R3 ext kept", ext_ops_en, 1);
            chk("R3 rom kept", rom_wp_en, 0);
            @(negedge clk);
            chk("R2 trap single cycle", trap_req, 0);
            if (inw) begin
                wr(8'h7F, 8'h00);
                chk("R4 exit after trap", super_mode, 0);
            end
        end
        rd(8'h7D, "R3 feature unchanged after trapped writes");

        // R8: reconfiguration works from user mode too.
        wr(8'hCF, 8'h42);
        chk("R8 recfg in user mode", reconfig_req, 1);
        chk("R8 no trap for recfg", trap_req, 0);

        // R1 R6: reset clears the sticky marker and features.
        do_reset();
        chk_reset_state();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule